// File: doc/BRIEF.md
# Display Transmit PHY Power Sequencer

This block drives the control register port of a combined MIPI / LVDS transmit PHY through its power-up and power-down orders. A start request with a mode code runs the bring-up order for that mode. A stop request runs the shared teardown order. Each step is one masked register write, described by a part index, an offset, a bit mask and a value. Some steps are followed by a timed gap. This gives the analog block its reset pulse width, and on the LVDS path the settle time of its PLL.

Writes leave at most one per cycle, marked by a strobe. Busy is high while an order is running. Done pulses once when the last write has left. A start with a mode code the block cannot bring up raises the error flag instead of running.

Both gap lengths are parameters counted in clock cycles. The divider values are captured when a start is accepted, so they may change while an order runs.

Top module: `phy_pwr_seq`

## Requirements
- R1: During and after reset, the write strobe, busy, done and error outputs are all low.
- R2: Every power-up order begins with two writes to part 0 (analog), offset 0x00: first mask 0x80 value 0x00 (bandgap on), then mask 0x03 value 0x01 (power-work on).
- R3: With mode 3'b001 (MIPI), the two R2 writes are followed by these writes, in this order, as (part, offset, mask, value):
  - (7, 0x03, 0x07, 0x01)
  - (0, 0x03, 0x1F, prediv)
  - (0, 0x03, 0x20, fbdiv bit 8 shifted to bit 5)
  - (0, 0x04, 0xFF, fbdiv[7:0])
  - (0, 0x01, 0x03, 0x00)
  - the R4 reset pulses
  - (0, 0x00, 0x7C, 0x7C)

  Here prediv and fbdiv are the input values captured when the start is accepted.
- R4: On the MIPI path, the analog sync reset (0, 0x01, mask 0x04) is written 0x04 and then 0x00. The digital reset (1, 0x00, mask 0x01) is then written 0x00 and then 0x01. Exactly SHORT_WAIT strobe-free cycles separate each assert write from its release.
- R5: With mode 3'b010 (LVDS), the two R2 writes are followed by these writes, in this order:
  - (0, 0x08, 0x10, 0x10)
  - (7, 0x03, 0x07, 0x02)
  - (0, 0x03, 0x1F, 0x02)
  - (0, 0x03, 0x20, 0x00)
  - (0, 0x04, 0xFF, 0x1C)
  - the R6 steps
  - (7, 0x01, 0x80, 0x80)
  - (7, 0x0B, 0xF8, 0xF8)
- R6: On the LVDS path, (7, 0x0B, 0x05, 0x00) is followed by exactly LONG_WAIT strobe-free cycles. Next comes (7, 0x00, 0x04, 0x00), exactly SHORT_WAIT strobe-free cycles, and then (7, 0x00, 0x04, 0x04).
- R7: A stop runs these writes, in this order:
  - (0, 0x00, 0x7C, 0x00)
  - (0, 0x01, 0x03, 0x03)
  - (0, 0x00, 0x03, 0x02)
  - (0, 0x00, 0x80, 0x80)
  - (7, 0x0B, 0xF8, 0x00)
  - (7, 0x01, 0x80, 0x00)
  - (7, 0x0B, 0x05, 0x05)
- R8: An accepted request makes busy high from the next cycle. The first write appears in that same cycle. Writes without a gap between them follow on consecutive cycles, and busy stays high through the last write.
- R9: In the cycle after the last write, busy is low and done is high for exactly that one cycle. A new request is accepted in that cycle.
- R10: A start or stop asserted while busy is high has no effect on the writes or flags.
- R11: A start when idle with any mode other than 3'b001 or 3'b010 issues no write and leaves busy low. It sets error from the next cycle, and error stays high until a later request is accepted.
- R12: A start and a stop asserted together while idle are treated as the start alone, including the R11 case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Power-up request |
| stop_i | input | 1 | Power-down request |
| mode_i | input | 3 | One-hot mode: bit0 MIPI, bit1 LVDS, bit2 TTL |
| prediv_i | input | 5 | Pre-divider for the MIPI path |
| fbdiv_i | input | 9 | Feedback divider for the MIPI path |
| wr_en_o | output | 1 | Write strobe, one write per cycle |
| wr_part_o | output | 3 | Register part index |
| wr_offset_o | output | 5 | Register offset within the part |
| wr_mask_o | output | 8 | Bits to modify |
| wr_value_o | output | 8 | New value of the masked bits |
| busy_o | output | 1 | An order is running |
| done_o | output | 1 | One-cycle pulse after the last write |
| error_o | output | 1 | Last start named an unsupported mode |

## Verification
A wrong step index or program selection shows up at the ports in the very cycle of the next strobe, as a wrong part, offset, mask or value. A gap counter that is loaded or decremented wrongly moves the next strobe earlier or later by a whole number of cycles, so the write after a reset pulse or the PLL settle gap lands in the wrong cycle. Flag state that leaks, such as a request accepted while busy or an error that does not clear, changes busy, done or the write stream within one cycle. For these reasons the bench compares every output against a behavioural model on every clock, rather than only checking end results.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int PART_W  = 3;
    localparam int OFS_W   = 5;
    localparam int DATA_W  = 8;
    localparam int PDIV_W  = 5;
    localparam int FBDIV_W = 9;
    localparam int STEP_W  = 4;

    localparam logic [PART_W-1:0] PART_ANA  = 3'd0;
    localparam logic [PART_W-1:0] PART_DIG  = 3'd1;
    localparam logic [PART_W-1:0] PART_LVDS = 3'd7;

    localparam logic [2:0] MODE_MIPI = 3'b001;
    localparam logic [2:0] MODE_LVDS = 3'b010;

    typedef enum logic [1:0] {PROG_UP_MIPI, PROG_UP_LVDS, PROG_DOWN} prog_e;
    typedef enum logic [1:0] {WT_NONE, WT_SHORT, WT_LONG} wait_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_WAIT} state_e;

    typedef struct packed {
        logic [PART_W-1:0] part;
        logic [OFS_W-1:0]  offset;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] value;
        wait_e             wt;
        logic              last;
    } step_t;

    function automatic step_t mk_step(logic [PART_W-1:0] part, logic [OFS_W-1:0] ofs,
                                      logic [DATA_W-1:0] mask, logic [DATA_W-1:0] val,
                                      wait_e wt, logic last);
        step_t s;
        s.part   = part;
        s.offset = ofs;
        s.mask   = mask;
        s.value  = val;
        s.wt     = wt;
        s.last   = last;
        return s;
    endfunction

endpackage

// File: rtl/phy_seq_step_table.sv
module phy_seq_step_table
    import phy_seq_pkg::*;
(
    input  prog_e                    prog_i,
    input  logic [STEP_W-1:0]        idx_i,
    input  logic [PDIV_W-1:0]        prediv_i,
    input  logic [FBDIV_W-1:0]       fbdiv_i,
    output step_t                    step_o
);

    localparam logic [DATA_W-1:0] LVDS_PDIV  = 8'd2;
    localparam logic [DATA_W-1:0] LVDS_FBDIV = 8'd28;

    logic [DATA_W-1:0] pdiv_val, fb_hi_val, fb_lo_val;

    always_comb begin
        pdiv_val  = DATA_W'(prediv_i);
        fb_hi_val = DATA_W'({fbdiv_i[FBDIV_W-1], 5'b0});
        fb_lo_val = fbdiv_i[DATA_W-1:0];
    end

    always_comb begin
        step_o = mk_step(PART_ANA, 5'h00, 8'h00, 8'h00, WT_NONE, 1'b1);
        if (prog_i == PROG_DOWN) begin
            case (idx_i)
                4'd0: step_o = mk_step(PART_ANA,  5'h00, 8'h7C, 8'h00, WT_NONE, 1'b0);
                4'd1: step_o = mk_step(PART_ANA,  5'h01, 8'h03, 8'h03, WT_NONE, 1'b0);
                4'd2: step_o = mk_step(PART_ANA,  5'h00, 8'h03, 8'h02, WT_NONE, 1'b0);
                4'd3: step_o = mk_step(PART_ANA,  5'h00, 8'h80, 8'h80, WT_NONE, 1'b0);
                4'd4: step_o = mk_step(PART_LVDS, 5'h0B, 8'hF8, 8'h00, WT_NONE, 1'b0);
                4'd5: step_o = mk_step(PART_LVDS, 5'h01, 8'h80, 8'h00, WT_NONE, 1'b0);
                4'd6: step_o = mk_step(PART_LVDS, 5'h0B, 8'h05, 8'h05, WT_NONE, 1'b1);
                default: ;
            endcase
        end else if (idx_i == 4'd0) begin
            step_o = mk_step(PART_ANA, 5'h00, 8'h80, 8'h00, WT_NONE, 1'b0);
        end else if (idx_i == 4'd1) begin
            step_o = mk_step(PART_ANA, 5'h00, 8'h03, 8'h01, WT_NONE, 1'b0);
        end else if (prog_i == PROG_UP_MIPI) begin
            case (idx_i)
                4'd2:  step_o = mk_step(PART_LVDS, 5'h03, 8'h07, MODE_MIPI, WT_NONE, 1'b0);
                4'd3:  step_o = mk_step(PART_ANA,  5'h03, 8'h1F, pdiv_val,  WT_NONE, 1'b0);
                4'd4:  step_o = mk_step(PART_ANA,  5'h03, 8'h20, fb_hi_val, WT_NONE, 1'b0);
                4'd5:  step_o = mk_step(PART_ANA,  5'h04, 8'hFF, fb_lo_val, WT_NONE, 1'b0);
                4'd6:  step_o = mk_step(PART_ANA,  5'h01, 8'h03, 8'h00, WT_NONE,  1'b0);
                4'd7:  step_o = mk_step(PART_ANA,  5'h01, 8'h04, 8'h04, WT_SHORT, 1'b0);
                4'd8:  step_o = mk_step(PART_ANA,  5'h01, 8'h04, 8'h00, WT_NONE,  1'b0);
                4'd9:  step_o = mk_step(PART_DIG,  5'h00, 8'h01, 8'h00, WT_SHORT, 1'b0);
                4'd10: step_o = mk_step(PART_DIG,  5'h00, 8'h01, 8'h01, WT_NONE,  1'b0);
                4'd11: step_o = mk_step(PART_ANA,  5'h00, 8'h7C, 8'h7C, WT_NONE,  1'b1);
                default: ;
            endcase
        end else begin
            case (idx_i)
                4'd2:  step_o = mk_step(PART_ANA,  5'h08, 8'h10, 8'h10, WT_NONE, 1'b0);
                4'd3:  step_o = mk_step(PART_LVDS, 5'h03, 8'h07, MODE_LVDS, WT_NONE, 1'b0);
                4'd4:  step_o = mk_step(PART_ANA,  5'h03, 8'h1F, LVDS_PDIV, WT_NONE, 1'b0);
                4'd5:  step_o = mk_step(PART_ANA,  5'h03, 8'h20, {2'b0, LVDS_FBDIV[7], 5'b0}, WT_NONE, 1'b0);
                4'd6:  step_o = mk_step(PART_ANA,  5'h04, 8'hFF, LVDS_FBDIV, WT_NONE, 1'b0);
                4'd7:  step_o = mk_step(PART_LVDS, 5'h0B, 8'h05, 8'h00, WT_LONG,  1'b0);
                4'd8:  step_o = mk_step(PART_LVDS, 5'h00, 8'h04, 8'h00, WT_SHORT, 1'b0);
                4'd9:  step_o = mk_step(PART_LVDS, 5'h00, 8'h04, 8'h04, WT_NONE,  1'b0);
                4'd10: step_o = mk_step(PART_LVDS, 5'h01, 8'h80, 8'h80, WT_NONE,  1'b0);
                4'd11: step_o = mk_step(PART_LVDS, 5'h0B, 8'hF8, 8'hF8, WT_NONE,  1'b1);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/phy_seq_wait_timer.sv
module phy_seq_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (dec_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R4 / R6: the sequencer never counts down a gap that has already run out
    p_dec_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_i |-> !expired_o);

    // R6: loading and counting are never requested together
    p_load_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && dec_i));

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_seq_pkg::*;
#(
    parameter int SHORT_WAIT = 100,
    parameter int LONG_WAIT  = 2000000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [2:0]         mode_i,
    input  logic [4:0]         prediv_i,
    input  logic [8:0]         fbdiv_i,
    output logic               wr_en_o,
    output logic [2:0]         wr_part_o,
    output logic [4:0]         wr_offset_o,
    output logic [7:0]         wr_mask_o,
    output logic [7:0]         wr_value_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o
);

    localparam int WAIT_MAX = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAIT - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAIT - 1);

    typedef struct packed {
        state_e               state;
        prog_e                prog;
        logic [STEP_W-1:0]    idx;
        logic [PDIV_W-1:0]    prediv;
        logic [FBDIV_W-1:0]   fbdiv;
        logic                 done;
        logic                 err;
    } ctl_t;

    ctl_t  r_d, r_q;
    step_t step;
    logic  mode_ok;
    logic  tmr_load, tmr_dec, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    phy_seq_step_table u_table (
        .prog_i   (r_q.prog),
        .idx_i    (r_q.idx),
        .prediv_i (r_q.prediv),
        .fbdiv_i  (r_q.fbdiv),
        .step_o   (step)
    );

    phy_seq_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .expired_o  (tmr_expired)
    );

    assign mode_ok = (mode_i == MODE_MIPI) || (mode_i == MODE_LVDS);
    assign tmr_val = (step.wt == WT_LONG) ? LONG_LD : SHORT_LD;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (mode_ok) begin
                        r_d.state  = ST_WRITE;
                        r_d.prog   = (mode_i == MODE_MIPI) ? PROG_UP_MIPI : PROG_UP_LVDS;
                        r_d.idx    = '0;
                        r_d.prediv = prediv_i;
                        r_d.fbdiv  = fbdiv_i;
                        r_d.err    = 1'b0;
                    end else begin
                        r_d.err    = 1'b1;
                    end
                end else if (stop_i) begin
                    r_d.state = ST_WRITE;
                    r_d.prog  = PROG_DOWN;
                    r_d.idx   = '0;
                    r_d.err   = 1'b0;
                end
            end
            ST_WRITE: begin
                if (step.last) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else if (step.wt != WT_NONE) begin
                    r_d.state = ST_WAIT;
                    tmr_load  = 1'b1;
                end else begin
                    r_d.idx   = r_q.idx + 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    r_d.state = ST_WRITE;
                    r_d.idx   = r_q.idx + 1'b1;
                end else begin
                    tmr_dec   = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state  <= ST_IDLE;
            r_q.prog   <= PROG_DOWN;
            r_q.idx    <= '0;
            r_q.prediv <= '0;
            r_q.fbdiv  <= '0;
            r_q.done   <= 1'b0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en_o     = (r_q.state == ST_WRITE);
    assign wr_part_o   = wr_en_o ? step.part   : '0;
    assign wr_offset_o = wr_en_o ? step.offset : '0;
    assign wr_mask_o   = wr_en_o ? step.mask   : '0;
    assign wr_value_o  = wr_en_o ? step.value  : '0;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = r_q.done;
    assign error_o     = r_q.err;

    // R9: done is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: done only follows a write and comes with busy low
    p_done_after_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(wr_en_o)));

    // R8: the last table step ends the order in the next cycle
    p_last_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && step.last) |=> (done_o && !wr_en_o));

    // R4: a gap that runs out is followed at once by the next write
    p_gap_then_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_WAIT && tmr_expired) |=> wr_en_o);

    // R10: the running program does not change while busy
    p_ignore_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (start_i || stop_i)) |=> (r_q.prog == $past(r_q.prog)));

    // R11: an unsupported mode raises error and starts nothing
    p_bad_mode_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && !mode_ok) |=> (error_o && !busy_o && !wr_en_o));

endmodule

// File: tb/tb_phy_pwr_seq.sv
`timescale 1ns/1ps
module tb_phy_pwr_seq;

    localparam int SW = 3;
    localparam int LW = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, stop = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [4:0] prediv = 5'd0;
    logic [8:0] fbdiv = 9'd0;
    logic       wr_en, busy, done, error;
    logic [2:0] wr_part;
    logic [4:0] wr_offset;
    logic [7:0] wr_mask, wr_value;

    always #2 clk = ~clk;

    phy_pwr_seq #(.SHORT_WAIT(SW), .LONG_WAIT(LW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .mode_i(mode),
        .prediv_i(prediv), .fbdiv_i(fbdiv), .wr_en_o(wr_en), .wr_part_o(wr_part),
        .wr_offset_o(wr_offset), .wr_mask_o(wr_mask), .wr_value_o(wr_value),
        .busy_o(busy), .done_o(done), .error_o(error)
    );

    typedef struct {
        bit       we;
        bit       bsy;
        bit       dn;
        bit [2:0] part;
        bit [4:0] ofs;
        bit [7:0] mask;
        bit [7:0] val;
        string    tag;
    } exp_t;

    exp_t q[$];
    bit   err_exp = 1'b0;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic pw(bit [2:0] p, bit [4:0] o, bit [7:0] m, bit [7:0] v, string tag);
        exp_t e;
        e.we = 1; e.bsy = 1; e.dn = 0; e.part = p; e.ofs = o; e.mask = m; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pgap(int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.we = 0; e.bsy = 1; e.dn = 0; e.part = 0; e.ofs = 0; e.mask = 0; e.val = 0; e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic pdone();
        exp_t e;
        e.we = 0; e.bsy = 0; e.dn = 1; e.part = 0; e.ofs = 0; e.mask = 0; e.val = 0; e.tag = "R9";
        q.push_back(e);
    endtask

    task automatic plan_common();
        pw(0, 5'h00, 8'h80, 8'h00, "R2");
        pw(0, 5'h00, 8'h03, 8'h01, "R2");
    endtask

    task automatic plan_mipi(bit [4:0] pd, bit [8:0] fb);
        plan_common();
        pw(7, 5'h03, 8'h07, 8'h01, "R3");
        pw(0, 5'h03, 8'h1F, {3'b0, pd}, "R3");
        pw(0, 5'h03, 8'h20, {2'b0, fb[8], 5'b0}, "R3");
        pw(0, 5'h04, 8'hFF, fb[7:0], "R3");
        pw(0, 5'h01, 8'h03, 8'h00, "R3");
        pw(0, 5'h01, 8'h04, 8'h04, "R4");
        pgap(SW, "R4");
        pw(0, 5'h01, 8'h04, 8'h00, "R4");
        pw(1, 5'h00, 8'h01, 8'h00, "R4");
        pgap(SW, "R4");
        pw(1, 5'h00, 8'h01, 8'h01, "R4");
        pw(0, 5'h00, 8'h7C, 8'h7C, "R3");
        pdone();
    endtask

    task automatic plan_lvds();
        plan_common();
        pw(0, 5'h08, 8'h10, 8'h10, "R5");
        pw(7, 5'h03, 8'h07, 8'h02, "R5");
        pw(0, 5'h03, 8'h1F, 8'h02, "R5");
        pw(0, 5'h03, 8'h20, 8'h00, "R5");
        pw(0, 5'h04, 8'hFF, 8'h1C, "R5");
        pw(7, 5'h0B, 8'h05, 8'h00, "R6");
        pgap(LW, "R6");
        pw(7, 5'h00, 8'h04, 8'h00, "R6");
        pgap(SW, "R6");
        pw(7, 5'h00, 8'h04, 8'h04, "R6");
        pw(7, 5'h01, 8'h80, 8'h80, "R5");
        pw(7, 5'h0B, 8'hF8, 8'hF8, "R5");
        pdone();
    endtask

    task automatic plan_down();
        pw(0, 5'h00, 8'h7C, 8'h00, "R7");
        pw(0, 5'h01, 8'h03, 8'h03, "R7");
        pw(0, 5'h00, 8'h03, 8'h02, "R7");
        pw(0, 5'h00, 8'h80, 8'h80, "R7");
        pw(7, 5'h0B, 8'hF8, 8'h00, "R7");
        pw(7, 5'h01, 8'h80, 8'h00, "R7");
        pw(7, 5'h0B, 8'h05, 8'h05, "R7");
        pdone();
    endtask

    // One cycle: compare at the falling edge, then drive the next request.
    task automatic tick(bit st, bit sp, bit [2:0] md);
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.we = 0; e.bsy = 0; e.dn = 0; e.part = 0; e.ofs = 0; e.mask = 0; e.val = 0; e.tag = "R8";
        end
        chk(e.tag, "wr_en", int'(wr_en), int'(e.we));
        chk(e.tag, "busy",  int'(busy),  int'(e.bsy));
        chk(e.tag, "done",  int'(done),  int'(e.dn));
        if (e.we) begin
            chk(e.tag, "part",   int'(wr_part),   int'(e.part));
            chk(e.tag, "offset", int'(wr_offset), int'(e.ofs));
            chk(e.tag, "mask",   int'(wr_mask),   int'(e.mask));
            chk(e.tag, "value",  int'(wr_value),  int'(e.val));
        end
        chk("R11", "error", int'(error), int'(err_exp));
        start = st; stop = sp; mode = md;
        if (q.size() == 0) begin
            if (st) begin
                if (md == 3'b001)      begin plan_mipi(prediv, fbdiv); err_exp = 0; end
                else if (md == 3'b010) begin plan_lvds(); err_exp = 0; end
                else                   err_exp = 1;
            end else if (sp) begin
                plan_down(); err_exp = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) tick(0, 0, 3'b000);
    endtask

    // R10: requests every cycle while busy, including the last write cycle
    task automatic drain_poke();
        while (q.size() > 1) tick(1, 1, 3'b010);
        tick(0, 0, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "wr_en", int'(wr_en), 0);
        chk("R1", "busy",  int'(busy),  0);
        chk("R1", "done",  int'(done),  0);
        chk("R1", "error", int'(error), 0);
        rst_n = 1'b1;
        @(negedge clk);
        tick(0, 0, 3'b000);
        tick(0, 0, 3'b000);

        // R3 R4: MIPI bring-up, inputs changed mid-run are not used
        prediv = 5'd3; fbdiv = 9'h1A5;
        tick(1, 0, 3'b001);
        prediv = 5'd17; fbdiv = 9'h033;
        drain_poke();
        tick(0, 0, 3'b000);

        // R7: teardown
        tick(0, 1, 3'b000);
        drain();
        tick(0, 0, 3'b000);

        // R5 R6: LVDS bring-up with requests during the run
        tick(1, 0, 3'b010);
        drain_poke();

        // R11: unsupported modes
        tick(1, 0, 3'b100);
        tick(0, 0, 3'b000);
        tick(1, 0, 3'b000);
        tick(1, 0, 3'b011);
        tick(0, 0, 3'b000);
        // R12: start wins over stop, also with a bad mode
        tick(1, 1, 3'b100);
        tick(0, 0, 3'b000);
        prediv = 5'd31; fbdiv = 9'h0FF;
        tick(1, 1, 3'b001);
        chk("R12", "busy", int'(busy), 1);
        // R9: a stop accepted in the done cycle starts the teardown at once
        while (q.size() > 1) tick(0, 0, 3'b000);
        tick(0, 1, 3'b000);
        drain();
        tick(0, 0, 3'b000);
        // MIPI with fbdiv bit 8 clear
        prediv = 5'd1; fbdiv = 9'h00C;
        tick(1, 0, 3'b001);
        drain();
        tick(0, 0, 3'b000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule